// File: doc/BRIEF.md
# BCD Calendar Clock Core with Snapshot Reads and Shadow Writes

This block keeps calendar time in binary-coded decimal: seconds, minutes, hours, date, month, a two-digit year, a century byte and a day-of-week count. A one-cycle pulse on `tick_1hz` advances it by one second. Hours run in either 24-hour or 12-hour form, chosen by the top bit of the hour byte. The calendar handles months shorter than 31 days and gives February a 29th day in every year whose two-digit value is a multiple of four.

The host reads the clock through a snapshot. A pulse on `snap_req` copies all eight bytes into a latch, and `rd_data` shows the latched byte that `rd_addr` selects. The live counters keep running during the read. The host writes through a shadow buffer. `wr_begin` opens a session and loads the buffer with the current time. Bytes then arrive on a valid/ready channel: a byte is taken in any cycle where `wr_valid` and `wr_ready` are both high, and `wr_ready` is high only while a session is open. A byte offered while `wr_ready` is low is dropped, not held. `wr_stop` commits the buffer to the counters if at least one byte was taken. `wr_abort` throws the buffer away. After reset, which models a total loss of power, a fail flag holds the counters still until the first committed write.

Byte map for both `rd_addr` and `wr_addr`: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 day of week, 7 century.

Top module: `rtcc_core`

## Requirements
- R1: After reset, `fail_o` is 1, `wr_ready` is 0, and the time is seconds 00, minutes 00, hour 8'h12 (12-hour mode, 12 AM), date 01, month 01, year 00, day of week 0 and century 8'h20.
- R2: Seconds and minutes count in BCD from 00 to 59. At 59 they wrap to 00 and carry into the next field. Otherwise the count goes up by one in BCD, so 09 is followed by 10.
- R3: When hour bit 7 is 1 (24-hour mode), bits 5:0 count BCD 00 to 23. After 23 the hour becomes 8'h80 and the date advances.
- R4: When hour bit 7 is 0 (12-hour mode), bits 4:0 hold BCD 1 to 12 and bit 5 is 1 for PM. The order is 11 AM, then 12 PM (8'h32), then 1 PM (8'h21), and later 11 PM (8'h31), then 12 AM (8'h12). The date advances only on the step from 11 PM to 12 AM.
- R5: The date wraps to 01 after the last day of its month. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February ends on 29 when the BCD year is a multiple of four and on 28 otherwise. The month wraps from 12 to 01 and carries into the year.
- R6: The year wraps from 99 to 00 and sets the century to 8'h20. The century only ever holds 8'h19 or 8'h20: a written 8'h19 is kept and any other written value becomes 8'h20. The day of week steps 0 through 6 and then back to 0, and a written value above 6 becomes 0.
- R7: A `snap_req` pulse copies all eight live bytes into the snapshot in the next cycle. `rd_data` shows the snapshot byte selected by `rd_addr`, and it stays unchanged while the clock ticks until the next `snap_req`.
- R8: `wr_begin` opens a session and copies the live time into the buffer. Each byte accepted with `wr_valid` and `wr_ready` high replaces one buffer byte. Written bytes are masked as follows: bit 7 of seconds and minutes is cleared, bit 6 of the hour is cleared, and only the low 6 bits of the date and the low 5 bits of the month are kept.
- R9: `wr_stop` in a session that accepted at least one byte loads the whole buffer into the counters and closes the session. Bytes that were not written keep the values copied at `wr_begin`.
- R10: `wr_abort` closes the session without changing the counters. So does `wr_stop` when no byte was accepted. A byte offered while `wr_ready` is 0 has no effect.
- R11: While `fail_o` is 1, ticks do not change the time. The first commit clears `fail_o`, and counting then resumes.
- R12: A tick in the same cycle as a commit is dropped, so the written values stand exactly. The next tick advances from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, models total power loss |
| tick_1hz | input | 1 | One-cycle pulse that advances time by one second |
| snap_req | input | 1 | Copies the live time into the read snapshot |
| rd_addr | input | 3 | Snapshot byte select |
| rd_data | output | 8 | Selected snapshot byte |
| wr_begin | input | 1 | Opens a write session and loads the buffer from live time |
| wr_stop | input | 1 | Ends the session and commits if any byte was taken |
| wr_abort | input | 1 | Ends the session and discards the buffer |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | High while a session is open |
| wr_addr | input | 3 | Buffer byte select |
| wr_data | input | 8 | Write byte value |
| fail_o | output | 1 | Power-fail flag; the clock is held while it is set |

## Verification
The hardest case to reach is a one-second tick that lands in the very cycle the shadow buffer is committed. It only happens when the host's stop lines up with the tick source. The bench forces it by raising `wr_stop` and `tick_1hz` on the same falling edge. It then reads back the written seconds unchanged, and after one more tick reads them advanced by exactly one. Cascades across several fields at once, such as the end of a century-year or the 11 PM to 12 AM step, are reached by writing a full time in one session and then issuing a single tick.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;
  localparam int NREG   = 8;
  localparam int ADDR_W = $clog2(NREG);
  localparam int I_SEC  = 0;
  localparam int I_MIN  = 1;
  localparam int I_HR   = 2;
  localparam int I_DATE = 3;
  localparam int I_MON  = 4;
  localparam int I_YR   = 5;
  localparam int I_DOW  = 6;
  localparam int I_CENT = 7;

  typedef logic [NREG-1:0][7:0] tvec_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // BCD year is a multiple of four: even tens with 0/4/8, odd tens with 2/6
  function automatic logic leap_yr(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_yr(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] clean_byte(input logic [ADDR_W-1:0] idx, input logic [7:0] d);
    case (idx)
      ADDR_W'(I_SEC), ADDR_W'(I_MIN): return {1'b0, d[6:0]};
      ADDR_W'(I_HR):   return {d[7], 1'b0, d[5:0]};
      ADDR_W'(I_DATE): return {2'b00, d[5:0]};
      ADDR_W'(I_MON):  return {3'b000, d[4:0]};
      ADDR_W'(I_DOW):  return (d > 8'd6) ? 8'd0 : d;
      ADDR_W'(I_CENT): return (d == 8'h19) ? 8'h19 : 8'h20;
      default:         return d;
    endcase
  endfunction
endpackage

// File: rtl/rtcc_advance.sv
module rtcc_advance
  import rtcc_pkg::*;
(
  input  tvec_t cur,
  output tvec_t nxt
);
  logic       c_min, c_hr, c_day, c_mon, c_yr;
  logic [7:0] inc_v;
  logic [4:0] h12;
  logic       pm;

  always_comb begin
    nxt   = cur;
    c_min = 1'b0; c_hr = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0;
    inc_v = 8'd0;
    h12   = cur[I_HR][4:0];
    pm    = cur[I_HR][5];

    if (cur[I_SEC] >= 8'h59) begin nxt[I_SEC] = 8'h00; c_min = 1'b1; end
    else nxt[I_SEC] = bcd_inc(cur[I_SEC]);

    if (c_min) begin
      if (cur[I_MIN] >= 8'h59) begin nxt[I_MIN] = 8'h00; c_hr = 1'b1; end
      else nxt[I_MIN] = bcd_inc(cur[I_MIN]);
    end

    if (c_hr) begin
      if (cur[I_HR][7]) begin
        inc_v = bcd_inc({2'b00, cur[I_HR][5:0]});
        if (cur[I_HR][5:0] >= 6'h23) begin nxt[I_HR] = 8'h80; c_day = 1'b1; end
        else nxt[I_HR] = {2'b10, inc_v[5:0]};
      end else begin
        inc_v = bcd_inc({3'b000, h12});
        if (h12 == 5'h11) begin
          nxt[I_HR] = {2'b00, ~pm, 5'h12};
          c_day     = pm;
        end else if (h12 >= 5'h12) nxt[I_HR] = {2'b00, pm, 5'h01};
        else nxt[I_HR] = {2'b00, pm, inc_v[4:0]};
      end
    end

    if (c_day) begin
      nxt[I_DOW] = (cur[I_DOW] >= 8'd6) ? 8'd0 : cur[I_DOW] + 8'd1;
      if (cur[I_DATE] >= month_end(cur[I_MON], cur[I_YR])) begin
        nxt[I_DATE] = 8'h01; c_mon = 1'b1;
      end else nxt[I_DATE] = bcd_inc(cur[I_DATE]);
    end

    if (c_mon) begin
      if (cur[I_MON] >= 8'h12) begin nxt[I_MON] = 8'h01; c_yr = 1'b1; end
      else nxt[I_MON] = bcd_inc(cur[I_MON]);
    end

    if (c_yr) begin
      if (cur[I_YR] >= 8'h99) begin nxt[I_YR] = 8'h00; nxt[I_CENT] = 8'h20; end
      else nxt[I_YR] = bcd_inc(cur[I_YR]);
    end
  end
endmodule

// File: rtl/rtcc_wrbuf.sv
module rtcc_wrbuf
  import rtcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tvec_t             live,
  input  logic              wr_begin,
  input  logic              wr_stop,
  input  logic              wr_abort,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              wr_ready,
  output tvec_t             buf_q,
  output logic              commit
);
  logic open_q, dirty_q;

  assign wr_ready = open_q;
  assign commit   = open_q && dirty_q && wr_stop && !wr_abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      dirty_q <= 1'b0;
      buf_q   <= '0;
    end else if (wr_abort || wr_stop) begin
      open_q  <= 1'b0;
      dirty_q <= 1'b0;
    end else if (wr_begin) begin
      open_q  <= 1'b1;
      dirty_q <= 1'b0;
      buf_q   <= live;
    end else if (wr_valid && open_q) begin
      buf_q[wr_addr] <= clean_byte(wr_addr, wr_data);
      dirty_q        <= 1'b1;
    end
  end
endmodule

// File: rtl/rtcc_snap.sv
module rtcc_snap
  import rtcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tvec_t             live,
  input  logic              snap_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output tvec_t             snap_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        snap_q <= '0;
    else if (snap_req) snap_q <= live;
  end

  assign rd_data = snap_q[rd_addr];
endmodule

// File: rtl/rtcc_core.sv
module rtcc_core
  import rtcc_pkg::*;
#(
  parameter logic [7:0] RST_HOUR = 8'h12,
  parameter logic [7:0] RST_CENT = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              snap_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              wr_begin,
  input  logic              wr_stop,
  input  logic              wr_abort,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              fail_o
);
  tvec_t live_q, next_w, buf_w, snap_w;
  logic  commit_w;
  tvec_t rst_time;

  always_comb begin
    rst_time         = '0;
    rst_time[I_HR]   = RST_HOUR;
    rst_time[I_DATE] = 8'h01;
    rst_time[I_MON]  = 8'h01;
    rst_time[I_CENT] = RST_CENT;
  end

  rtcc_advance u_adv (.cur(live_q), .nxt(next_w));

  rtcc_wrbuf u_wr (
    .clk(clk), .rst_n(rst_n), .live(live_q),
    .wr_begin(wr_begin), .wr_stop(wr_stop), .wr_abort(wr_abort),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .buf_q(buf_w), .commit(commit_w)
  );

  rtcc_snap u_snap (
    .clk(clk), .rst_n(rst_n), .live(live_q), .snap_req(snap_req),
    .rd_addr(rd_addr), .rd_data(rd_data), .snap_q(snap_w)
  );

  // commit outranks a coincident tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= rst_time;
      fail_o <= 1'b1;
    end else if (commit_w) begin
      live_q <= buf_w;
      fail_o <= 1'b0;
    end else if (tick_1hz && !fail_o) begin
      live_q <= next_w;
    end
  end
endmodule

// File: rtl/rtcc_checker.sv
module rtcc_checker
  import rtcc_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  snap_req,
  input logic  wr_abort,
  input logic  wr_ready,
  input logic  commit,
  input logic  fail_o,
  input tvec_t live,
  input tvec_t buf_q,
  input tvec_t snap
);
  a_r11_frozen_while_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !commit) |=> $stable(live));

  a_r11_commit_clears_fail: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !fail_o);

  a_r12_commit_value_exact: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (live == $past(buf_q)));

  a_r10_abort_closes: assert property (@(posedge clk) disable iff (!rst_n)
    wr_abort |=> !wr_ready);

  a_r7_snapshot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_req |=> $stable(snap));

  a_r6_century_values: assert property (@(posedge clk) disable iff (!rst_n)
    (live[I_CENT] == 8'h19) || (live[I_CENT] == 8'h20));

  a_r6_dow_range: assert property (@(posedge clk) disable iff (!rst_n)
    live[I_DOW] < 8'd7);
endmodule

bind rtcc_core rtcc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .snap_req(snap_req), .wr_abort(wr_abort),
  .wr_ready(wr_ready), .commit(commit_w), .fail_o(fail_o),
  .live(live_q), .buf_q(buf_w), .snap(snap_w)
);

// File: tb/rtcc_core_tb.sv
module rtcc_core_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0, snap_req = 1'b0;
  logic [2:0] rd_addr = '0, wr_addr = '0;
  logic [7:0] rd_data, wr_data = '0;
  logic       wr_begin = 1'b0, wr_stop = 1'b0, wr_abort = 1'b0, wr_valid = 1'b0;
  logic       wr_ready, fail_o;
  int         errors = 0, checks = 0;
  logic       done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtcc_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .snap_req(snap_req),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_begin(wr_begin), .wr_stop(wr_stop),
    .wr_abort(wr_abort), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .fail_o(fail_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) tick_1hz = 1'b1;
    @(negedge clk) tick_1hz = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk) snap_req = 1'b1;
    @(negedge clk) begin snap_req = 1'b0; rd_addr = a; end
    #1 v = rd_data;
  endtask

  task automatic wr_open();
    @(negedge clk) wr_begin = 1'b1;
    @(negedge clk) wr_begin = 1'b0;
  endtask

  task automatic wr_byte(input logic [2:0] a, input logic [7:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk) wr_valid = 1'b0;
  endtask

  task automatic wr_close();
    wr_stop = 1'b1;
    @(negedge clk) wr_stop = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, d, mo, y, w, c);
    wr_open();
    wr_byte(0, s); wr_byte(1, m); wr_byte(2, h); wr_byte(3, d);
    wr_byte(4, mo); wr_byte(5, y); wr_byte(6, w); wr_byte(7, c);
    wr_close();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    #1;
    chk("R1 fail_o", {7'd0, fail_o}, 8'd1);
    chk("R1 wr_ready", {7'd0, wr_ready}, 8'd0);
    rd(0, v); chk("R1 sec", v, 8'h00);
    rd(2, v); chk("R1 hour", v, 8'h12);
    rd(3, v); chk("R1 date", v, 8'h01);
    rd(4, v); chk("R1 month", v, 8'h01);
    rd(6, v); chk("R1 dow", v, 8'h00);
    rd(7, v); chk("R1 century", v, 8'h20);
    tick(); tick(); tick();
    rd(0, v); chk("R11 held while fail", v, 8'h00);
  endtask

  task automatic t_first_write();
    logic [7:0] v;
    wr_open(); wr_byte(0, 8'h30); wr_close();
    #1 chk("R11 fail cleared", {7'd0, fail_o}, 8'd0);
    rd(0, v); chk("R9 written sec", v, 8'h30);
    rd(2, v); chk("R9 hour kept", v, 8'h12);
    tick();
    rd(0, v); chk("R11 counting resumed", v, 8'h31);
  endtask

  task automatic t_sec_min();
    logic [7:0] v;
    set_time(8'h09, 8'h00, 8'h81, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20);
    tick(); rd(0, v); chk("R2 09->10", v, 8'h10);
    set_time(8'h59, 8'h09, 8'h81, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20);
    tick(); rd(0, v); chk("R2 sec wrap", v, 8'h00);
    rd(1, v); chk("R2 min carry", v, 8'h10);
  endtask

  task automatic t_century_rollover();
    logic [7:0] v;
    set_time(8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 8'h06, 8'h19);
    tick();
    rd(2, v); chk("R3 23->00", v, 8'h80);
    rd(3, v); chk("R5 date wrap", v, 8'h01);
    rd(4, v); chk("R5 month wrap", v, 8'h01);
    rd(5, v); chk("R6 year wrap", v, 8'h00);
    rd(7, v); chk("R6 century step", v, 8'h20);
    rd(6, v); chk("R6 dow wrap", v, 8'h00);
  endtask

  task automatic t_12h();
    logic [7:0] v;
    set_time(8'h59, 8'h59, 8'h11, 8'h05, 8'h03, 8'h10, 8'h02, 8'h20);
    tick(); rd(2, v); chk("R4 11AM->12PM", v, 8'h32);
    rd(3, v); chk("R4 no date step at noon", v, 8'h05);
    set_time(8'h59, 8'h59, 8'h32, 8'h05, 8'h03, 8'h10, 8'h02, 8'h20);
    tick(); rd(2, v); chk("R4 12PM->1PM", v, 8'h21);
    set_time(8'h59, 8'h59, 8'h31, 8'h05, 8'h03, 8'h10, 8'h02, 8'h20);
    tick(); rd(2, v); chk("R4 11PM->12AM", v, 8'h12);
    rd(3, v); chk("R4 date step at midnight", v, 8'h06);
  endtask

  task automatic t_month_ends();
    logic [7:0] v;
    set_time(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h24, 8'h00, 8'h20);
    tick(); rd(3, v); chk("R5 leap feb 29", v, 8'h29);
    set_time(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h12, 8'h00, 8'h20);
    tick(); rd(3, v); chk("R5 leap odd tens", v, 8'h29);
    set_time(8'h59, 8'h59, 8'hA3, 8'h29, 8'h02, 8'h24, 8'h00, 8'h20);
    tick(); rd(4, v); chk("R5 feb29->mar", v, 8'h03);
    set_time(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h23, 8'h00, 8'h20);
    tick(); rd(3, v); chk("R5 non-leap date", v, 8'h01);
    rd(4, v); chk("R5 non-leap month", v, 8'h03);
    set_time(8'h59, 8'h59, 8'hA3, 8'h30, 8'h04, 8'h23, 8'h00, 8'h20);
    tick(); rd(4, v); chk("R5 april end", v, 8'h05);
  endtask

  task automatic t_write_clean();
    logic [7:0] v;
    set_time(8'hD5, 8'h00, 8'hC1, 8'hC5, 8'hE3, 8'h10, 8'h07, 8'h55);
    rd(7, v); chk("R6 century forced", v, 8'h20);
    rd(6, v); chk("R6 dow forced", v, 8'h00);
    rd(0, v); chk("R8 sec mask", v, 8'h55);
    rd(2, v); chk("R8 hour mask", v, 8'h81);
    rd(3, v); chk("R8 date mask", v, 8'h05);
    rd(4, v); chk("R8 month mask", v, 8'h03);
  endtask

  task automatic t_snapshot();
    logic [7:0] v;
    set_time(8'h20, 8'h00, 8'h81, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20);
    rd(0, v); chk("R7 snap", v, 8'h20);
    tick(); tick();
    #1 chk("R7 snap held", rd_data, 8'h20);
    rd(0, v); chk("R7 resnap", v, 8'h22);
  endtask

  task automatic t_discard();
    logic [7:0] v;
    set_time(8'h40, 8'h12, 8'h81, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20);
    wr_open(); wr_byte(0, 8'h44);
    wr_abort = 1'b1; @(negedge clk) wr_abort = 1'b0;
    #1 chk("R10 ready low after abort", {7'd0, wr_ready}, 8'd0);
    rd(0, v); chk("R10 abort discards", v, 8'h40);
    wr_open(); wr_close();
    rd(0, v); chk("R10 empty stop", v, 8'h40);
    wr_byte(0, 8'h33); wr_close();
    rd(0, v); chk("R10 byte without ready", v, 8'h40);
    wr_open(); wr_byte(1, 8'h45); wr_close();
    rd(1, v); chk("R9 partial min", v, 8'h45);
    rd(0, v); chk("R9 partial sec kept", v, 8'h40);
  endtask

  task automatic t_commit_tick();
    logic [7:0] v;
    wr_open(); wr_byte(0, 8'h10);
    @(negedge clk) begin wr_stop = 1'b0; end
    wr_stop = 1'b1; tick_1hz = 1'b1;
    @(negedge clk) begin wr_stop = 1'b0; tick_1hz = 1'b0; end
    rd(0, v); chk("R12 tick dropped", v, 8'h10);
    tick(); rd(0, v); chk("R12 next tick", v, 8'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_write();
    t_sec_min();
    t_century_rollover();
    t_12h();
    t_month_ends();
    t_write_clean();
    t_snapshot();
    t_discard();
    t_commit_tick();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule